// File: doc/BRIEF.md
# Sampled PID Loop Compensator

This block closes a digital position or velocity loop. Each control period, a tick makes it sample two 20-bit counts: a commanded count and a measured feedback count. It forms their signed difference at 21 bits. From that difference it computes proportional, integral and derivative contributions in 40-bit fixed point. The weighted sum is scaled down by a fixed 16-bit shift and clamped to a signed 16-bit range. The result is then re-coded as offset binary for a 16-bit DAC.

A single multiplier is shared across the three terms. It is stepped by a short sequencer, so one result takes four clock cycles after the tick is accepted, far inside any practical control period. The DAC word is a register. It changes only once per accepted tick and holds its value for the rest of the period. The integral accumulator saturates at the level that already drives the output to full scale, so it never winds up beyond the point of effect.

Top module: `pid_comp`

## Requirements
- R1: While `rst` is high and after it falls, `dac_code` reads 16'h8000 (offset-binary zero), and both the integral accumulator and the stored previous error are zero.
- R2: The error is the 21-bit signed difference of the two counts, each taken as 20-bit two's complement and sign-extended. Extreme counts such as 20'h7FFFF minus 20'h80000 (+1048575) do not wrap.
- R3: With signed 16-bit gains `gain_p`, `gain_i` and `gain_d`, each accepted sample yields q = (gain_p*e + I + gain_d*(e - e_prev)) >>> 16 (arithmetic shift). Here I is the integral accumulator after it has added gain_i*e for this same sample.
- R4: A tick is accepted on a rising edge while the block is idle. `dac_code` takes the new value on the fourth rising edge after that edge and stays unchanged on every other edge. Gains must be held stable from the tick until the update.
- R5: q is clamped to the range -32768 to +32767 before output.
- R6: After each addition, the integral accumulator is clamped to the range -2^31 to 2^31-1. The full-scale output state is therefore left on the first sample whose error reverses the sum.
- R7: `dac_code` equals the clamped two's-complement value with bit 15 inverted (offset binary: -32768 gives 16'h0000, 0 gives 16'h8000, +32767 gives 16'hFFFF).
- R8: A tick that arrives while a computation is in progress is ignored. It does not restart the sequence, does not resample the counts and does not change the stored previous error.
- R9: The derivative term uses the difference between the current error and the error of the previous accepted sample. The previous error is taken as zero for the first sample after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Control-period strobe that starts one computation |
| cmd_cnt | input | 20 | Commanded count, two's complement |
| fbk_cnt | input | 20 | Feedback count, two's complement |
| gain_p | input | 16 | Proportional gain, signed |
| gain_i | input | 16 | Integral gain, signed |
| gain_d | input | 16 | Derivative gain, signed |
| dac_code | output | 16 | Offset-binary word for the DAC |

## Verification
Every result is due on the fourth rising edge after the edge that accepts the tick. The bench raises the tick for exactly one edge. After the three following edges it confirms that the previous DAC word is still present, and after the fourth it compares the new word with a reference model. All inputs change on falling edges and all outputs are sampled there. The busy-tick case drives a second tick two edges after the first, so it falls inside the computation. The effect of the ignored tick then shows both in that result and in the derivative of the next one.

// File: rtl/pid_pkg.sv
package pid_pkg;
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_P,
    PH_I,
    PH_D,
    PH_S
  } phase_t;
endpackage

// File: rtl/pid_err_stage.sv
module pid_err_stage #(
  parameter int CNT_W = 20,
  localparam int E_W = CNT_W + 1,
  localparam int D_W = CNT_W + 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [CNT_W-1:0]      cmd_cnt,
  input  logic [CNT_W-1:0]      fbk_cnt,
  output logic signed [E_W-1:0] err_q,
  output logic signed [D_W-1:0] derr_q
);
  logic signed [E_W-1:0] err_now;
  logic signed [E_W-1:0] prev_q;
  logic signed [D_W-1:0] derr_now;

  // one extra bit keeps the difference of two counts exact
  assign err_now  = $signed({cmd_cnt[CNT_W-1], cmd_cnt}) - $signed({fbk_cnt[CNT_W-1], fbk_cnt});
  assign derr_now = $signed({err_now[E_W-1], err_now}) - $signed({prev_q[E_W-1], prev_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q  <= '0;
      derr_q <= '0;
      prev_q <= '0;
    end else if (load) begin
      err_q  <= err_now;
      derr_q <= derr_now;
      prev_q <= err_now;
    end
  end
endmodule

// File: rtl/pid_mul_share.sv
module pid_mul_share
  import pid_pkg::*;
#(
  parameter int GAIN_W = 16,
  parameter int OP_W   = 22,
  parameter int ACC_W  = 40,
  localparam int PROD_W = GAIN_W + OP_W
) (
  input  phase_t                   phase,
  input  logic signed [GAIN_W-1:0] gain_p,
  input  logic signed [GAIN_W-1:0] gain_i,
  input  logic signed [GAIN_W-1:0] gain_d,
  input  logic signed [OP_W-2:0]   err,
  input  logic signed [OP_W-1:0]   derr,
  output logic signed [ACC_W-1:0]  prod
);
  logic signed [GAIN_W-1:0] gain_sel;
  logic signed [OP_W-1:0]   opnd_sel;
  logic signed [PROD_W-1:0] prod_full;

  // operand steering so that a single multiplier serves all three terms
  always_comb begin
    case (phase)
      PH_I: begin
        gain_sel = gain_i;
        opnd_sel = $signed({err[OP_W-2], err});
      end
      PH_D: begin
        gain_sel = gain_d;
        opnd_sel = derr;
      end
      default: begin
        gain_sel = gain_p;
        opnd_sel = $signed({err[OP_W-2], err});
      end
    endcase
  end

  assign prod_full = gain_sel * opnd_sel;

  generate
    if (ACC_W > PROD_W) begin : g_ext
      assign prod = $signed({{(ACC_W-PROD_W){prod_full[PROD_W-1]}}, prod_full});
    end else begin : g_trim
      assign prod = prod_full[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/pid_integ.sv
module pid_integ #(
  parameter int ACC_W = 40,
  parameter int LIM_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [ACC_W-1:0] prod,
  output logic signed [ACC_W-1:0] integ_q
);
  localparam logic signed [ACC_W:0] HI = {{(ACC_W-LIM_W+2){1'b0}}, {(LIM_W-1){1'b1}}};
  localparam logic signed [ACC_W:0] LO = ~HI;

  logic signed [ACC_W:0] sum;
  logic signed [ACC_W:0] nxt;

  assign sum = $signed({integ_q[ACC_W-1], integ_q}) + $signed({prod[ACC_W-1], prod});

  // anti-windup: stop where the output would already be at full scale
  always_comb begin
    if (sum > HI)      nxt = HI;
    else if (sum < LO) nxt = LO;
    else               nxt = sum;
  end

  always_ff @(posedge clk) begin
    if (rst)     integ_q <= '0;
    else if (en) integ_q <= nxt[ACC_W-1:0];
  end
endmodule

// File: rtl/pid_out_stage.sv
module pid_out_stage #(
  parameter int ACC_W = 40,
  parameter int FRAC  = 16,
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic signed [ACC_W-1:0] acc,
  input  logic signed [ACC_W-1:0] integ,
  output logic [OUT_W-1:0]        sat_word,
  output logic [OUT_W-1:0]        dac_code
);
  localparam int S_W = ACC_W + 1;
  localparam logic signed [S_W-1:0] HI = {{(S_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [S_W-1:0] LO = ~HI;

  logic signed [S_W-1:0] total;
  logic signed [S_W-1:0] scaled;
  logic signed [S_W-1:0] clamped;

  assign total  = $signed({acc[ACC_W-1], acc}) + $signed({integ[ACC_W-1], integ});
  assign scaled = total >>> FRAC;

  always_comb begin
    if (scaled > HI)      clamped = HI;
    else if (scaled < LO) clamped = LO;
    else                  clamped = scaled;
  end

  assign sat_word = clamped[OUT_W-1:0];

  // offset binary: flip the sign bit of the two's-complement word
  always_ff @(posedge clk) begin
    if (rst)       dac_code <= {1'b1, {(OUT_W-1){1'b0}}};
    else if (load) dac_code <= {~sat_word[OUT_W-1], sat_word[OUT_W-2:0]};
  end
endmodule

// File: rtl/pid_comp.sv
module pid_comp
  import pid_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int GAIN_W = 16,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 16,
  parameter int FRAC   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic [CNT_W-1:0]  fbk_cnt,
  input  logic [GAIN_W-1:0] gain_p,
  input  logic [GAIN_W-1:0] gain_i,
  input  logic [GAIN_W-1:0] gain_d,
  output logic [OUT_W-1:0]  dac_code
);
  localparam int E_W   = CNT_W + 1;
  localparam int D_W   = CNT_W + 2;
  localparam int LIM_W = OUT_W + FRAC;

  phase_t phase;
  logic   take;
  logic   out_load;
  logic signed [E_W-1:0]   err_q;
  logic signed [D_W-1:0]   derr_q;
  logic signed [ACC_W-1:0] prod;
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] integ_q;
  logic [OUT_W-1:0]        sat_word;

  assign take     = (phase == PH_IDLE) && tick;
  assign out_load = (phase == PH_S);

  // sequencer: sample, P, I, D, then output
  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: if (tick) phase <= PH_P;
        PH_P:    phase <= PH_I;
        PH_I:    phase <= PH_D;
        PH_D:    phase <= PH_S;
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 acc_q <= '0;
    else if (phase == PH_P)  acc_q <= prod;
    else if (phase == PH_D)  acc_q <= acc_q + prod;
  end

  pid_err_stage #(.CNT_W(CNT_W)) u_err (
    .clk     (clk),
    .rst     (rst),
    .load    (take),
    .cmd_cnt (cmd_cnt),
    .fbk_cnt (fbk_cnt),
    .err_q   (err_q),
    .derr_q  (derr_q)
  );

  pid_mul_share #(.GAIN_W(GAIN_W), .OP_W(D_W), .ACC_W(ACC_W)) u_mul (
    .phase  (phase),
    .gain_p ($signed(gain_p)),
    .gain_i ($signed(gain_i)),
    .gain_d ($signed(gain_d)),
    .err    (err_q),
    .derr   (derr_q),
    .prod   (prod)
  );

  pid_integ #(.ACC_W(ACC_W), .LIM_W(LIM_W)) u_integ (
    .clk     (clk),
    .rst     (rst),
    .en      (phase == PH_I),
    .prod    (prod),
    .integ_q (integ_q)
  );

  pid_out_stage #(.ACC_W(ACC_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_out (
    .clk      (clk),
    .rst      (rst),
    .load     (out_load),
    .acc      (acc_q),
    .integ    (integ_q),
    .sat_word (sat_word),
    .dac_code (dac_code)
  );
endmodule

// File: rtl/pid_comp_chk.sv
module pid_comp_chk
  import pid_pkg::*;
#(
  parameter int ACC_W = 40,
  parameter int LIM_W = 32,
  parameter int OUT_W = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick,
  input phase_t                  phase,
  input logic                    out_load,
  input logic signed [ACC_W-1:0] integ_q,
  input logic [OUT_W-1:0]        sat_word,
  input logic [OUT_W-1:0]        dac_code
);
  localparam logic signed [ACC_W-1:0] I_HI = {{(ACC_W-LIM_W+1){1'b0}}, {(LIM_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] I_LO = ~I_HI;

  // R4: the result lands four edges after an accepted tick
  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && tick) |-> ##4 out_load);

  // R4: the DAC word holds except right after an output step
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !out_load |=> $stable(dac_code));

  // R6: the integral never leaves its clamp window
  p_integ_bound_r6: assert property (@(posedge clk) disable iff (rst)
    (integ_q <= I_HI) && (integ_q >= I_LO));

  // R7: the sign bit is inverted on the way to the DAC
  p_offset_r7: assert property (@(posedge clk) disable iff (rst)
    out_load |=> (dac_code[OUT_W-1] != $past(sat_word[OUT_W-1]))
                 && (dac_code[OUT_W-2:0] == $past(sat_word[OUT_W-2:0])));

  // R8: a tick during a computation never restarts it
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && tick) |=> (phase != PH_P));
endmodule

bind pid_comp pid_comp_chk #(.ACC_W(ACC_W), .LIM_W(LIM_W), .OUT_W(OUT_W)) chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .phase    (phase),
  .out_load (out_load),
  .integ_q  (integ_q),
  .sat_word (sat_word),
  .dac_code (dac_code)
);

// File: tb/pid_comp_test.sv
module pid_comp_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [19:0] cmd_cnt = '0;
  logic [19:0] fbk_cnt = '0;
  logic [15:0] gain_p = '0;
  logic [15:0] gain_i = '0;
  logic [15:0] gain_d = '0;
  logic [15:0] dac_code;

  int     checks = 0;
  int     errors = 0;
  longint m_prev = 0;
  longint m_integ = 0;
  logic [15:0] exp_code = 16'h8000;

  always #2 clk = ~clk;

  pid_comp uut (
    .clk(clk), .rst(rst), .tick(tick),
    .cmd_cnt(cmd_cnt), .fbk_cnt(fbk_cnt),
    .gain_p(gain_p), .gain_i(gain_i), .gain_d(gain_d),
    .dac_code(dac_code)
  );

  function automatic logic [15:0] model(input logic [19:0] c, input logic [19:0] f,
                                        input logic [15:0] p, input logic [15:0] i,
                                        input logic [15:0] d);
    longint e, de, s, q;
    e  = longint'($signed(c)) - longint'($signed(f));
    de = e - m_prev;
    m_prev = e;
    m_integ = m_integ + longint'($signed(i)) * e;
    if (m_integ > 64'sd2147483647) m_integ = 64'sd2147483647;
    if (m_integ < -64'sd2147483648) m_integ = -64'sd2147483648;
    s = longint'($signed(p)) * e + m_integ + longint'($signed(d)) * de;
    q = s >>> 16;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q[15:0] ^ 16'h8000;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 during reset", dac_code, 16'h8000);
    rst = 1'b0;
    m_prev = 0;
    m_integ = 0;
    exp_code = 16'h8000;
    @(negedge clk);
    check("R1 after reset", dac_code, 16'h8000);
  endtask

  task automatic sample(input logic [19:0] c, input logic [19:0] f, input logic [15:0] p,
                        input logic [15:0] i, input logic [15:0] d,
                        input string req, input bit extra);
    logic [15:0] nxt;
    @(negedge clk);
    cmd_cnt = c; fbk_cnt = f; gain_p = p; gain_i = i; gain_d = d;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    nxt = model(c, f, p, i, d);
    @(negedge clk);
    if (extra) begin
      tick = 1'b1;
      cmd_cnt = ~c;
    end
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
    check({"R4 hold ", req}, dac_code, exp_code);
    @(negedge clk);
    check(req, dac_code, nxt);
    exp_code = nxt;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1957));
    do_reset();

    sample(20'h12345, 20'h00321, 16'h0000, 16'h0000, 16'h0000, "R3 zero gains", 1'b0);
    check("R7 zero code", dac_code, 16'h8000);
    sample(20'h7FFFF, 20'h80000, 16'h0001, 16'h0000, 16'h0000, "R2 max positive error", 1'b0);
    check("R2 code 800F", dac_code, 16'h800F);
    sample(20'h80000, 20'h7FFFF, 16'h0001, 16'h0000, 16'h0000, "R2 max negative error", 1'b0);
    check("R2 code 7FF0", dac_code, 16'h7FF0);
    sample(20'h40000, 20'h00000, 16'h7FFF, 16'h0000, 16'h0000, "R5 upper clamp", 1'b0);
    check("R7 full scale", dac_code, 16'hFFFF);
    sample(20'hC0000, 20'h00000, 16'h7FFF, 16'h0000, 16'h0000, "R5 lower clamp", 1'b0);
    check("R7 minus full scale", dac_code, 16'h0000);

    do_reset();
    for (int k = 0; k < 6; k++)
      sample(20'h7FFFF, 20'h80000, 16'h0000, 16'h7FFF, 16'h0000, "R6 windup", 1'b0);
    sample(20'h80000, 20'h7FFFF, 16'h0000, 16'h7FFF, 16'h0000, "R6 release", 1'b0);
    sample(20'h00010, 20'h00000, 16'h0000, 16'h0100, 16'h0000, "R6 after release", 1'b0);

    do_reset();
    sample(20'h01000, 20'h00000, 16'h0000, 16'h0000, 16'h4000, "R9 first sample", 1'b0);
    sample(20'h03000, 20'h00000, 16'h0000, 16'h0000, 16'h4000, "R9 step up", 1'b0);
    sample(20'h00000, 20'h00800, 16'h0000, 16'h0000, 16'h4000, "R9 step down", 1'b0);
    sample(20'h02000, 20'h00100, 16'h0200, 16'h0010, 16'h1000, "R8 busy tick", 1'b1);
    sample(20'h02100, 20'h00100, 16'h0200, 16'h0010, 16'h1000, "R8 after busy tick", 1'b0);

    for (int k = 0; k < 120; k++) begin
      logic [19:0] c, f;
      logic [15:0] p, i, d;
      c = 20'($urandom);
      f = (k % 3 == 0) ? 20'($urandom) : c - 20'($signed(12'($urandom)));
      p = 16'($urandom);
      i = (k % 2 == 0) ? 16'($signed(8'($urandom))) : 16'($urandom);
      d = 16'($urandom);
      sample(c, f, p, i, d, (k % 2 == 0) ? "R3 random" : "R7 random", (k % 17 == 5));
    end

    do_reset();
    sample(20'h00400, 20'h00000, 16'h1000, 16'h0100, 16'h0800, "R1 state cleared", 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule